// File: doc/BRIEF.md
# Two-Bank Flash Command Sequencer

This block sits behind the bus-cycle qualifier of a two-bank flash device. It receives qualified write cycles, each an address and a data byte, and decodes the multi-cycle unlock sequences that start a program, a sector erase or an identification (autoselect) read. It also handles erase suspend and resume, and the reset command. It keeps one mode per bank. The most significant address bits pick the bank. Each bank decodes commands on its own, so one bank can accept commands while the other is busy.

The embedded program and erase algorithms are modelled by down-counters of configurable length. A per-bank test input forces the operation-failure flag. A failed operation leaves the bank in an error mode until a reset command is written. The reset command is honoured only in certain states. It is accepted between sequence cycles, in autoselect and in error. It is ignored while an embedded operation runs. It returns a bank with a suspended erase to the suspended-read mode rather than to plain read.

Writes enter through a valid/ready port. `wr_ready` is low during reset and high from the first clock edge after reset is released. From then on every write offered with `wr_valid` high is accepted on the next rising edge, so the port never applies back-pressure. A write presented while `wr_valid` is low has no effect.

Top module: `flcmd_sequencer`

## Requirements
- R1: After reset every bank reports mode 0 (read), `busy` and `error` are low, no start pulse is raised, and `wr_ready` is high.
- R2: The writes 0xAA at offset 0x555, 0x55 at offset 0x2AA, 0xA0 at offset 0x555 and then any address and data to the same bank start a program. `prog_start` pulses for one cycle. The mode becomes 2 (program) and stays there for exactly PROG_CYCLES cycles, then returns to 0.
- R3: The writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA and then 0x30 at any address start a sector erase. `erase_start` pulses for one cycle. The mode becomes 3 (erase) for ERASE_CYCLES cycles, then 0.
- R4: A write with a wrong address or data value, or a correct value out of order, drops the partial sequence. The bank stays in its base mode: 0, or 4 when an erase is suspended.
- R5: Data 0xF0 at any address, written between sequence cycles, cancels the partial sequence.
- R6: While a bank is in mode 2 or 3, a 0xF0 write to it is ignored and the operation runs to completion.
- R7: 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 enters mode 1 (autoselect). Other writes leave the bank there, and only 0xF0 leaves it.
- R8: When `fail_req` of a busy bank is high at a clock edge, the bank enters mode 5 (error) and `error` goes high. It stays there until a 0xF0 write, which returns it to mode 0, or to mode 4 if the bank holds a suspended erase.
- R9: 0xB0 written to a bank in mode 3 enters mode 4 (erase-suspended read) and freezes the erase count. In mode 4, a program sequence runs and returns to mode 4. A lone 0x30 write resumes the erase in mode 3, which then finishes and returns to mode 0.
- R10: In mode 4, a 0xF0 that cancels a program sequence, or that ends an autoselect entered from mode 4, returns the bank to mode 4.
- R11: The top address bit selects the bank. Writes to one bank do not change the mode of the other, and a bank can take a command sequence while the other is busy.
- R12: A write offered with `wr_valid` low is not accepted and does not advance any sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write cycle offered |
| wr_ready | output | 1 | Write accepted on the edge when high together with wr_valid |
| wr_addr | input | ADDR_W | Word address; the top bit selects the bank |
| wr_data | input | DATA_W | Write data; the low byte is decoded |
| fail_req | input | NUM_BANKS | Test input: forces the failure flag of a busy bank |
| bank_mode | output | 3*NUM_BANKS | Mode of bank b at bits [3b+2:3b]: 0 read, 1 autoselect, 2 program, 3 erase, 4 erase-suspended, 5 error |
| prog_start | output | NUM_BANKS | One-cycle pulse when a program starts |
| erase_start | output | NUM_BANKS | One-cycle pulse when a sector erase starts |
| busy | output | NUM_BANKS | Bank is in mode 2 or 3 |
| error | output | NUM_BANKS | Bank is in mode 5 |

## Verification
Every result is registered. A write accepted at a rising edge therefore shows its effect on `bank_mode`, `prog_start` and `erase_start` in the cycle that follows that edge. The bench drives each write for one cycle from a falling edge and samples at the next falling edge. A program holds mode 2 for exactly PROG_CYCLES cycles counted from the accepting edge. The bench checks mode 2 after PROG_CYCLES-1 further edges and mode 0 one edge later, and uses the same edge count for erase with ERASE_CYCLES. A forced failure and a suspend are each checked one edge after the edge that takes them in.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_AUTOSEL = 3'd1,
    MD_PROG    = 3'd2,
    MD_ERASE   = 3'd3,
    MD_SUSP    = 3'd4,
    MD_ERROR   = 3'd5
  } bank_mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PDATA,
    SQ_ESET,
    SQ_EUNL1,
    SQ_EUNL2
  } seq_e;

  // classification of one write cycle
  typedef struct packed {
    logic at_a1;    // offset is first unlock address
    logic at_a2;    // offset is second unlock address
    logic d_aa;
    logic d_55;
    logic d_prog;
    logic d_eset;
    logic d_asel;
    logic d_reset;
    logic d_susp;
    logic d_go;     // sector erase / resume byte
  } wr_class_t;

  localparam logic [15:0] OFS_UNLOCK1 = 16'h0555;
  localparam logic [15:0] OFS_UNLOCK2 = 16'h02AA;
  localparam logic [7:0]  BYTE_KEY1   = 8'hAA;
  localparam logic [7:0]  BYTE_KEY2   = 8'h55;
  localparam logic [7:0]  BYTE_PROG   = 8'hA0;
  localparam logic [7:0]  BYTE_ESET   = 8'h80;
  localparam logic [7:0]  BYTE_ASEL   = 8'h90;
  localparam logic [7:0]  BYTE_RESET  = 8'hF0;
  localparam logic [7:0]  BYTE_SUSP   = 8'hB0;
  localparam logic [7:0]  BYTE_GO     = 8'h30;

endpackage

// File: rtl/flcmd_decode.sv
module flcmd_decode
  import flcmd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output wr_class_t         cls,
  output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] bank_sel
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned OFS_W  = ADDR_W - BANK_W;

  logic [OFS_W-1:0] ofs;
  logic [7:0]       cmd;

  assign ofs      = addr[OFS_W-1:0];
  assign bank_sel = addr[ADDR_W-1 -: BANK_W];
  assign cmd      = data[7:0];

  always_comb begin
    cls.at_a1   = (ofs == OFS_W'(OFS_UNLOCK1));
    cls.at_a2   = (ofs == OFS_W'(OFS_UNLOCK2));
    cls.d_aa    = (cmd == BYTE_KEY1);
    cls.d_55    = (cmd == BYTE_KEY2);
    cls.d_prog  = (cmd == BYTE_PROG);
    cls.d_eset  = (cmd == BYTE_ESET);
    cls.d_asel  = (cmd == BYTE_ASEL);
    cls.d_reset = (cmd == BYTE_RESET);
    cls.d_susp  = (cmd == BYTE_SUSP);
    cls.d_go    = (cmd == BYTE_GO);
  end

  if (DATA_W > 8) begin : g_hi_unused
    logic unused_hi;
    assign unused_hi = ^data[DATA_W-1:8];
  end

endmodule

// File: rtl/flcmd_optimer.sv
module flcmd_optimer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int unsigned CW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= CW'(LEN - 1);
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/flcmd_bank.sv
module flcmd_bank
  import flcmd_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 16,
  parameter int unsigned ERASE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  wr_class_t  cls,
  input  logic       fail_req,
  output bank_mode_e mode,
  output logic       prog_start,
  output logic       erase_start
);
  bank_mode_e mode_q, mode_n;
  seq_e       seq_q, seq_n;
  logic       susp_q, susp_n;
  logic       ps_q, ps_n, es_q, es_n;
  logic       p_load, e_load, p_run, e_run, p_zero, e_zero;
  logic       base_mode;

  assign base_mode = (mode_q == MD_READ) || (mode_q == MD_SUSP);

  flcmd_optimer #(.LEN(PROG_CYCLES)) u_prog_tmr (
    .clk(clk), .rst_n(rst_n), .load(p_load), .run(p_run), .zero(p_zero)
  );

  flcmd_optimer #(.LEN(ERASE_CYCLES)) u_erase_tmr (
    .clk(clk), .rst_n(rst_n), .load(e_load), .run(e_run), .zero(e_zero)
  );

  assign p_run = (mode_q == MD_PROG) && !fail_req;
  assign e_run = (mode_q == MD_ERASE) && !fail_req && !(hit && cls.d_susp);

  always_comb begin
    mode_n = mode_q;
    seq_n  = seq_q;
    susp_n = susp_q;
    p_load = 1'b0;
    e_load = 1'b0;
    ps_n   = 1'b0;
    es_n   = 1'b0;
    unique case (mode_q)
      MD_PROG: begin
        if (fail_req)     mode_n = MD_ERROR;
        else if (p_zero)  mode_n = susp_q ? MD_SUSP : MD_READ;
      end
      MD_ERASE: begin
        if (fail_req)                 mode_n = MD_ERROR;
        else if (e_zero)              mode_n = MD_READ;
        else if (hit && cls.d_susp) begin
          mode_n = MD_SUSP;
          susp_n = 1'b1;
        end
      end
      MD_ERROR, MD_AUTOSEL: begin
        if (hit && cls.d_reset) mode_n = susp_q ? MD_SUSP : MD_READ;
      end
      default: begin
        if (hit) begin
          if (cls.d_reset) begin
            seq_n = SQ_IDLE;
          end else begin
            unique case (seq_q)
              SQ_IDLE: begin
                if (mode_q == MD_SUSP && cls.d_go) begin
                  mode_n = MD_ERASE;
                  susp_n = 1'b0;
                end else if (cls.d_aa && cls.at_a1) begin
                  seq_n = SQ_UNL1;
                end
              end
              SQ_UNL1:  seq_n = (cls.d_55 && cls.at_a2) ? SQ_UNL2 : SQ_IDLE;
              SQ_UNL2: begin
                seq_n = SQ_IDLE;
                if (cls.at_a1 && cls.d_prog)       seq_n  = SQ_PDATA;
                else if (cls.at_a1 && cls.d_asel)  mode_n = MD_AUTOSEL;
                else if (cls.at_a1 && cls.d_eset && mode_q == MD_READ)
                                                   seq_n  = SQ_ESET;
              end
              SQ_PDATA: begin
                seq_n  = SQ_IDLE;
                mode_n = MD_PROG;
                p_load = 1'b1;
                ps_n   = 1'b1;
              end
              SQ_ESET:  seq_n = (cls.d_aa && cls.at_a1) ? SQ_EUNL1 : SQ_IDLE;
              SQ_EUNL1: seq_n = (cls.d_55 && cls.at_a2) ? SQ_EUNL2 : SQ_IDLE;
              SQ_EUNL2: begin
                seq_n = SQ_IDLE;
                if (cls.d_go) begin
                  mode_n = MD_ERASE;
                  e_load = 1'b1;
                  es_n   = 1'b1;
                end
              end
              default:  seq_n = SQ_IDLE;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_READ;
      seq_q  <= SQ_IDLE;
      susp_q <= 1'b0;
      ps_q   <= 1'b0;
      es_q   <= 1'b0;
    end else begin
      mode_q <= mode_n;
      seq_q  <= seq_n;
      susp_q <= susp_n;
      ps_q   <= ps_n;
      es_q   <= es_n;
    end
  end

  assign mode        = mode_q;
  assign prog_start  = ps_q;
  assign erase_start = es_q;

  AST_PROG_RESET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_PROG && hit && cls.d_reset && !fail_req && !p_zero) |=> mode_q == MD_PROG); // R6
  AST_ERASE_RESET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ERASE && hit && cls.d_reset && !fail_req && !e_zero) |=> mode_q == MD_ERASE); // R6
  AST_AUTOSEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_AUTOSEL && !(hit && cls.d_reset)) |=> mode_q == MD_AUTOSEL); // R7
  AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ERROR && !(hit && cls.d_reset)) |=> mode_q == MD_ERROR); // R8
  AST_PSTART_IN_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> mode_q == MD_PROG); // R2
  AST_ESTART_IN_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (mode_q == MD_ERASE && !prog_start)); // R3
  AST_SUSPEND_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ERASE && hit && cls.d_susp && !fail_req && !e_zero) |=> mode_q == MD_SUSP); // R9
  AST_BUSY_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_PROG || mode_q == MD_ERASE) && fail_req) |=> mode_q == MD_ERROR); // R8

endmodule

// File: rtl/flcmd_sequencer.sv
module flcmd_sequencer
  import flcmd_pkg::*;
#(
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned NUM_BANKS    = 2,
  parameter int unsigned PROG_CYCLES  = 16,
  parameter int unsigned ERASE_CYCLES = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_BANKS-1:0]   fail_req,
  output logic [3*NUM_BANKS-1:0] bank_mode,
  output logic [NUM_BANKS-1:0]   prog_start,
  output logic [NUM_BANKS-1:0]   erase_start,
  output logic [NUM_BANKS-1:0]   busy,
  output logic [NUM_BANKS-1:0]   error
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              rdy_q;
  logic              accept;
  wr_class_t         cls;
  logic [BANK_W-1:0] bank_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign wr_ready = rdy_q;
  assign accept   = wr_valid && rdy_q;

  flcmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)) u_decode (
    .addr(wr_addr), .data(wr_data), .cls(cls), .bank_sel(bank_sel)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_mode_e mode_w;
    logic       hit_w;

    assign hit_w = accept && (bank_sel == BANK_W'(b));

    flcmd_bank #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_bank (
      .clk(clk), .rst_n(rst_n), .hit(hit_w), .cls(cls), .fail_req(fail_req[b]),
      .mode(mode_w), .prog_start(prog_start[b]), .erase_start(erase_start[b])
    );

    assign bank_mode[3*b +: 3] = mode_w;
    assign busy[b]  = (mode_w == MD_PROG) || (mode_w == MD_ERASE);
    assign error[b] = (mode_w == MD_ERROR);

    AST_OTHER_BANK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_w && mode_w == MD_AUTOSEL) |=> mode_w == MD_AUTOSEL); // R11
  end

  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |=> wr_ready); // R1

endmodule

// File: tb/flcmd_sequencer_bench.sv
module flcmd_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PCYC = 6;
  localparam int ECYC = 10;
  localparam int NB   = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [11:0]      wr_addr = '0;
  logic [7:0]       wr_data = '0;
  logic [NB-1:0]    fail_req = '0;
  logic [3*NB-1:0]  bank_mode;
  logic [NB-1:0]    prog_start, erase_start, busy, error;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flcmd_sequencer #(.PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC)) u_flcmd_sequencer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .fail_req(fail_req),
    .bank_mode(bank_mode), .prog_start(prog_start), .erase_start(erase_start),
    .busy(busy), .error(error)
  );

  function automatic int md(input int b);
    return int'(bank_mode[3*b +: 3]);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int b, input logic [10:0] ofs, input logic [7:0] d);
    wr_valid = 1'b1;
    wr_addr  = {b[0], ofs};
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock(input int b);
    wr(b, 11'h555, 8'hAA);
    wr(b, 11'h2AA, 8'h55);
  endtask

  task automatic start_prog(input int b);
    unlock(b);
    wr(b, 11'h555, 8'hA0);
    wr(b, 11'h0123, 8'h5A);
  endtask

  task automatic start_erase(input int b);
    unlock(b);
    wr(b, 11'h555, 8'h80);
    unlock(b);
    wr(b, 11'h0400, 8'h30);
  endtask

  task automatic t_reset_state;
    chk("R1 mode0", md(0), 0);
    chk("R1 mode1", md(1), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 error", int'(error), 0);
    chk("R1 starts", int'({prog_start, erase_start}), 0);
    chk("R1 ready", int'(wr_ready), 1);
  endtask

  task automatic t_valid_low;
    // first unlock cycle offered without valid: the sequence must not advance
    wr_addr = 12'h555; wr_data = 8'hAA; tick();
    wr(0, 11'h2AA, 8'h55);
    wr(0, 11'h555, 8'hA0);
    wr(0, 11'h010, 8'h11);
    chk("R12 no start", int'(prog_start[0]), 0);
    chk("R12 mode", md(0), 0);
  endtask

  task automatic t_program;
    start_prog(0);
    chk("R2 pulse", int'(prog_start[0]), 1);
    chk("R2 mode prog", md(0), 2);
    chk("R2 busy", int'(busy[0]), 1);
    tick();
    chk("R2 pulse one cycle", int'(prog_start[0]), 0);
    tick(PCYC - 2);
    chk("R2 still prog", md(0), 2);
    tick();
    chk("R2 done read", md(0), 0);
  endtask

  task automatic t_erase;
    start_erase(1);
    chk("R3 pulse", int'(erase_start[1]), 1);
    chk("R3 mode erase", md(1), 3);
    chk("R3 other bank", md(0), 0);
    tick(ECYC - 1);
    chk("R3 still erase", md(1), 3);
    tick();
    chk("R3 done read", md(1), 0);
  endtask

  task automatic t_abort;
    wr(0, 11'h555, 8'hAA);
    wr(0, 11'h555, 8'hAA);   // out of order
    wr(0, 11'h2AA, 8'h55);
    wr(0, 11'h555, 8'hA0);
    wr(0, 11'h020, 8'h22);
    chk("R4 order abort", int'(prog_start[0]), 0);
    chk("R4 order mode", md(0), 0);
    wr(0, 11'h555, 8'hAA);
    wr(0, 11'h2AB, 8'h55);   // wrong address
    wr(0, 11'h555, 8'hA0);
    wr(0, 11'h020, 8'h22);
    chk("R4 addr abort", int'(prog_start[0]), 0);
    chk("R4 addr mode", md(0), 0);
  endtask

  task automatic t_reset_between;
    unlock(0);
    wr(0, 11'h123, 8'hF0);
    wr(0, 11'h555, 8'hA0);
    wr(0, 11'h030, 8'h33);
    chk("R5 prog seq cancelled", int'(prog_start[0]), 0);
    chk("R5 mode", md(0), 0);
    unlock(0);
    wr(0, 11'h555, 8'h80);
    wr(0, 11'h7FF, 8'hF0);
    unlock(0);
    wr(0, 11'h400, 8'h30);
    chk("R5 erase seq cancelled", int'(erase_start[0]), 0);
    chk("R5 mode after erase seq", md(0), 0);
  endtask

  task automatic t_busy_reset;
    start_prog(0);
    wr(0, 11'h000, 8'hF0);
    chk("R6 prog ignores reset", md(0), 2);
    tick(PCYC);
    chk("R6 prog completes", md(0), 0);
    start_erase(0);
    wr(0, 11'h555, 8'hF0);
    chk("R6 erase ignores reset", md(0), 3);
    tick(ECYC);
    chk("R6 erase completes", md(0), 0);
  endtask

  task automatic t_autosel;
    unlock(1);
    wr(1, 11'h555, 8'h90);
    chk("R7 enter", md(1), 1);
    wr(1, 11'h555, 8'hAA);
    wr(1, 11'h2AA, 8'h55);
    wr(1, 11'h555, 8'hA0);
    wr(1, 11'h001, 8'h01);
    chk("R7 held", md(1), 1);
    chk("R7 no program", int'(prog_start[1]), 0);
    wr(1, 11'h3C3, 8'hF0);
    chk("R7 exit", md(1), 0);
  endtask

  task automatic t_error;
    start_prog(0);
    fail_req[0] = 1'b1;
    tick();
    fail_req[0] = 1'b0;
    chk("R8 error mode", md(0), 5);
    chk("R8 error flag", int'(error[0]), 1);
    tick(PCYC + 2);
    wr(0, 11'h555, 8'h00);
    chk("R8 sticky", md(0), 5);
    wr(0, 11'h111, 8'hF0);
    chk("R8 reset to read", md(0), 0);
    chk("R8 flag cleared", int'(error[0]), 0);
  endtask

  task automatic t_suspend;
    start_erase(0);
    tick(2);
    wr(0, 11'h000, 8'hB0);
    chk("R9 suspended", md(0), 4);
    tick(ECYC + 3);
    chk("R9 frozen", md(0), 4);
    start_prog(0);
    chk("R9 prog in suspend", md(0), 2);
    tick(PCYC);
    chk("R9 back to suspend", md(0), 4);
    unlock(0);
    wr(0, 11'h555, 8'hA0);
    wr(0, 11'h222, 8'hF0);
    chk("R10 prog seq reset", md(0), 4);
    wr(0, 11'h040, 8'h44);
    chk("R10 no prog", int'(prog_start[0]), 0);
    unlock(0);
    wr(0, 11'h555, 8'h90);
    chk("R10 autosel", md(0), 1);
    wr(0, 11'h000, 8'hF0);
    chk("R10 autosel exit", md(0), 4);
    start_prog(0);
    fail_req[0] = 1'b1;
    tick();
    fail_req[0] = 1'b0;
    chk("R8 error in suspend", md(0), 5);
    wr(0, 11'h000, 8'hF0);
    chk("R8 reset to suspend", md(0), 4);
    wr(0, 11'h000, 8'h30);
    chk("R9 resumed", md(0), 3);
    tick(ECYC + 1);
    chk("R9 erase finished", md(0), 0);
  endtask

  task automatic t_banks;
    start_prog(0);
    unlock(1);
    wr(1, 11'h555, 8'h90);
    chk("R11 bank1 autosel", md(1), 1);
    chk("R11 bank0 busy", md(0), 2);
    tick(PCYC);
    chk("R11 bank0 done", md(0), 0);
    chk("R11 bank1 held", md(1), 1);
    wr(1, 11'h000, 8'hF0);
    chk("R11 bank1 read", md(1), 0);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(2);
    t_reset_state();
    t_valid_low();
    t_program();
    t_erase();
    t_abort();
    t_reset_between();
    t_busy_reset();
    t_autosel();
    t_error();
    t_suspend();
    t_banks();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule